// File: doc/BRIEF.md
# Push-Pull PWM Steering Controller

This block is the digital core of a two-switch push-pull converter controller. A free-running counter serves as the oscillator ramp. Each wrap of that counter ends one oscillator period. A short blanking pulse opens each period. A divide-by-two steering flop hands consecutive periods to switch A and switch B in turn. A switch output is high only when three conditions hold together: the blanking pulse is idle, the steering flop points at that switch, and the ramp is still below the effective duty command. Because of this, the two outputs can never overlap, and the blanking window gives a fixed minimum dead time between them.

The duty command arrives as a digital word. The block takes a new value only at the period boundary. A current-limit input passes through a synchronizer. Once it fires, it cuts off the pulse in progress for the rest of that period. A slow up/down integrator counts limited periods against clean periods. Its value is subtracted from the duty command, so a sustained overload walks the duty down smoothly and clean operation walks it back up. The analog error amplifier, the gate drivers and the power stage sit outside this block.

Top module: `pp_pwm_steer`

## Requirements
- R1: While `rst` is high both outputs are low. A synchronous reset clears the ramp to 0, clears the steering flop to select A, and clears the loaded duty and the integrator to 0. The first period after reset therefore produces no pulse.
- R2: The ramp counts 0 to `TERM_CNT` and wraps, so one period is `TERM_CNT`+1 clocks. The steering flop toggles at every wrap. Periods after reset are assigned A, B, A, B, and so on, starting with A for the first period.
- R3: `drv_a` and `drv_b` are never high in the same cycle. Both are low in the blanking window, which covers ramp values 0 to `BLANK_CYCLES`-1.
- R4: The selected output is high for ramp values r with `BLANK_CYCLES` <= r < D, where D is the loaded effective duty. The pulse width is therefore max(0, min(D, `TERM_CNT`+1) - `BLANK_CYCLES`) clocks. It is 0 when D <= `BLANK_CYCLES`, and the pulse runs to the end of the period when D > `TERM_CNT`.
- R5: `duty_cmd` is sampled only in the cycle where the ramp equals `TERM_CNT`, and the sampled value governs the following period. A change made in the middle of a period does not alter that period's pulse.
- R6: `ilim_in` passes through a two-stage synchronizer. If it is high before clock edge k, the active output is forced low from edge k+2 and stays low for the rest of the period, even after `ilim_in` falls.
- R7: A period is limited if the synchronized current-limit signal was seen high in any of its cycles. At each wrap the integrator adds 1 after a limited period, saturating at 2^`INT_W`-1. After a clean period it subtracts 1, stopping at 0.
- R8: The duty loaded at a wrap is `duty_cmd` minus the integrator value held before that wrap's update, saturating at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the ramp advances once per cycle |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | CNT_W | Digital duty command in ramp counts |
| ilim_in | input | 1 | Asynchronous over-current flag, active high |
| drv_a | output | 1 | Drive pulse for switch A |
| drv_b | output | 1 | Drive pulse for switch B |

## Verification
Two actions can land on the same clock edge. The current-limit latch may set at the same moment the ramp wraps, the integrator steps and a new duty is loaded. The integrator may also be stepping while a duty change from the outside is being sampled. The bench provokes this in three ways: a one-cycle current-limit pulse in the middle of an A period, a current-limit level held across twenty wraps until the integrator saturates, and a release timed to a period boundary. Each cycle is judged against a behavioural model, and the widths of the following periods are checked against the sequence the subtraction rule predicts: one period of lag, then a decay of one count per clean period.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

   // Steering phase: low selects switch A, high selects switch B.
   typedef enum logic {
      SEL_A = 1'b0,
      SEL_B = 1'b1
   } steer_e;

   // Number of switch channels driven by the steering stage.
   localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pp_ramp_osc.sv
module pp_ramp_osc
   import pp_pwm_pkg::*;
#(
   parameter int unsigned CNT_W        = 10,
   parameter int unsigned TERM_CNT     = 499,
   parameter int unsigned BLANK_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] ramp_o,
   output logic             wrap_o,
   output logic             blank_o,
   output steer_e           phase_o
);

   localparam logic [CNT_W-1:0] TERM_V  = CNT_W'(TERM_CNT);
   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYCLES);

   initial begin : g_param_chk
      assert (TERM_CNT < (2 ** CNT_W))
         else $fatal(1, "pp_ramp_osc: TERM_CNT does not fit CNT_W");
      assert (BLANK_CYCLES > 0 && BLANK_CYCLES < TERM_CNT)
         else $fatal(1, "pp_ramp_osc: BLANK_CYCLES out of range");
   end

   logic [CNT_W-1:0] ramp_q;
   steer_e           phase_q;
   logic             at_term;

   assign at_term = (ramp_q == TERM_V);

   // Ramp counter and divide-by-two steering flop.
   always_ff @(posedge clk) begin
      if (rst) begin
         ramp_q  <= '0;
         phase_q <= SEL_A;
      end else if (at_term) begin
         ramp_q  <= '0;
         phase_q <= (phase_q == SEL_A) ? SEL_B : SEL_A;
      end else begin
         ramp_q  <= ramp_q + 1'b1;
      end
   end

   assign ramp_o  = ramp_q;
   assign wrap_o  = at_term;
   assign blank_o = (ramp_q < BLANK_V);
   assign phase_o = phase_q;

endmodule

// File: rtl/pp_ilim_catch.sv
module pp_ilim_catch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ilim_i,
   input  logic wrap_i,
   output logic hit_o,
   output logic period_lim_o
);

   initial begin : g_param_chk
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "pp_ilim_catch: at least two synchronizer stages required");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ilim_s;
   logic                   hit_q;

   // Synchronizer chain, one flop per stage.
   genvar st;
   generate
      for (st = 0; st < SYNC_STAGES; st++) begin : g_sync
         if (st == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) sync_q[st] <= 1'b0;
               else     sync_q[st] <= ilim_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) sync_q[st] <= 1'b0;
               else     sync_q[st] <= sync_q[st-1];
            end
         end
      end
   endgenerate

   assign ilim_s = sync_q[SYNC_STAGES-1];

   // Cut latch: holds until the period boundary.
   always_ff @(posedge clk) begin
      if (rst)         hit_q <= 1'b0;
      else if (wrap_i) hit_q <= 1'b0;
      else if (ilim_s) hit_q <= 1'b1;
   end

   assign hit_o        = hit_q;
   assign period_lim_o = hit_q | ilim_s;

endmodule

// File: rtl/pp_sd_integ.sv
module pp_sd_integ #(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned INT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap_i,
   input  logic             period_lim_i,
   input  logic [CNT_W-1:0] duty_cmd_i,
   output logic [CNT_W-1:0] duty_q_o,
   output logic [INT_W-1:0] integ_o
);

   initial begin : g_param_chk
      assert (INT_W >= 1 && INT_W <= CNT_W)
         else $fatal(1, "pp_sd_integ: INT_W must lie in 1..CNT_W");
   end

   localparam logic [INT_W-1:0] INT_MAX = '1;

   logic [INT_W-1:0] integ_q;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] integ_ext;
   logic [CNT_W:0]   diff;
   logic [CNT_W-1:0] duty_eff;

   assign integ_ext = CNT_W'(integ_q);
   assign diff      = {1'b0, duty_cmd_i} - {1'b0, integ_ext};
   assign duty_eff  = diff[CNT_W] ? '0 : diff[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         integ_q <= '0;
         duty_q  <= '0;
      end else if (wrap_i) begin
         duty_q <= duty_eff;
         if (period_lim_i) begin
            if (integ_q != INT_MAX) integ_q <= integ_q + 1'b1;
         end else begin
            if (integ_q != '0)      integ_q <= integ_q - 1'b1;
         end
      end
   end

   assign duty_q_o = duty_q;
   assign integ_o  = integ_q;

endmodule

// File: rtl/pp_steer_out.sv
module pp_steer_out
   import pp_pwm_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic               rst,
   input  logic [CNT_W-1:0]   ramp_i,
   input  logic [CNT_W-1:0]   duty_i,
   input  logic               blank_i,
   input  steer_e             phase_i,
   input  logic               hit_i,
   output logic [NUM_CH-1:0]  drv_o
);

   logic cmp_hi;   // high once the ramp has reached the duty
   logic phase_b;

   assign cmp_hi  = (ramp_i >= duty_i) | hit_i;
   assign phase_b = (phase_i == SEL_B);

   // Each channel fires only when all three inhibit terms are low.
   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic sel_inh;
         if (ch == 0) begin : g_a
            assign sel_inh = phase_b;
         end else begin : g_b
            assign sel_inh = ~phase_b;
         end
         assign drv_o[ch] = ~(blank_i | sel_inh | cmp_hi) & ~rst;
      end
   endgenerate

endmodule

// File: rtl/pp_pwm_steer.sv
module pp_pwm_steer
   import pp_pwm_pkg::*;
#(
   parameter int unsigned CNT_W        = 10,
   parameter int unsigned TERM_CNT     = 499,
   parameter int unsigned BLANK_CYCLES = 4,
   parameter int unsigned INT_W        = 8,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] duty_cmd,
   input  logic             ilim_in,
   output logic             drv_a,
   output logic             drv_b
);

   logic [CNT_W-1:0]  ramp_w;
   logic              wrap_w;
   logic              blank_w;
   steer_e            phase_w;
   logic              hit_w;
   logic              plim_w;
   logic [CNT_W-1:0]  duty_w;
   logic [INT_W-1:0]  integ_w;
   logic [NUM_CH-1:0] drv_w;

   pp_ramp_osc #(
      .CNT_W        (CNT_W),
      .TERM_CNT     (TERM_CNT),
      .BLANK_CYCLES (BLANK_CYCLES)
   ) u_osc (
      .clk     (clk),
      .rst     (rst),
      .ramp_o  (ramp_w),
      .wrap_o  (wrap_w),
      .blank_o (blank_w),
      .phase_o (phase_w)
   );

   pp_ilim_catch #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ilim (
      .clk          (clk),
      .rst          (rst),
      .ilim_i       (ilim_in),
      .wrap_i       (wrap_w),
      .hit_o        (hit_w),
      .period_lim_o (plim_w)
   );

   pp_sd_integ #(
      .CNT_W (CNT_W),
      .INT_W (INT_W)
   ) u_integ (
      .clk          (clk),
      .rst          (rst),
      .wrap_i       (wrap_w),
      .period_lim_i (plim_w),
      .duty_cmd_i   (duty_cmd),
      .duty_q_o     (duty_w),
      .integ_o      (integ_w)
   );

   pp_steer_out #(
      .CNT_W (CNT_W)
   ) u_out (
      .rst     (rst),
      .ramp_i  (ramp_w),
      .duty_i  (duty_w),
      .blank_i (blank_w),
      .phase_i (phase_w),
      .hit_i   (hit_w),
      .drv_o   (drv_w)
   );

   assign drv_a = drv_w[0];
   assign drv_b = drv_w[1];

endmodule

// File: rtl/pp_pwm_steer_chk.sv
module pp_pwm_steer_chk #(
   parameter int unsigned CNT_W        = 10,
   parameter int unsigned TERM_CNT     = 499,
   parameter int unsigned BLANK_CYCLES = 4,
   parameter int unsigned INT_W        = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] ramp,
   input logic [CNT_W-1:0] duty_q,
   input logic [INT_W-1:0] integ,
   input logic             hit,
   input logic             drv_a,
   input logic             drv_b
);

   localparam logic [CNT_W-1:0] TERM_V  = CNT_W'(TERM_CNT);
   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYCLES);

   // R1: reset keeps both drives low
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |-> (!drv_a && !drv_b));

   // R2: wrap at the terminal count
   p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (ramp == TERM_V) |=> (ramp == '0));

   // R2: count by one elsewhere
   p_count_r2: assert property (@(posedge clk) disable iff (rst)
      (ramp != TERM_V) |=> (ramp == $past(ramp) + 1'b1));

   // R3: no overlap
   p_excl_r3: assert property (@(posedge clk) disable iff (rst)
      !(drv_a && drv_b));

   // R3: dead time in the blanking window
   p_blank_r3: assert property (@(posedge clk) disable iff (rst)
      (ramp < BLANK_V) |-> (!drv_a && !drv_b));

   // R5: loaded duty only moves at a period start
   p_duty_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (ramp != '0) |-> $stable(duty_q));

   // R6: a cut stays in force until the wrap
   p_cut_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && ramp != TERM_V) |=> (!drv_a && !drv_b));

   // R7: integrator only steps at a period start
   p_integ_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ramp != '0) |-> $stable(integ));

endmodule

bind pp_pwm_steer pp_pwm_steer_chk #(
   .CNT_W        (CNT_W),
   .TERM_CNT     (TERM_CNT),
   .BLANK_CYCLES (BLANK_CYCLES),
   .INT_W        (INT_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .ramp   (ramp_w),
   .duty_q (duty_w),
   .integ  (integ_w),
   .hit    (hit_w),
   .drv_a  (drv_a),
   .drv_b  (drv_b)
);

// File: tb/pp_pwm_steer_tb.sv
module pp_pwm_steer_tb;

   localparam int CNT_W = 10;
   localparam int TERM  = 499;
   localparam int BL    = 4;
   localparam int INT_W = 4;
   localparam int IMAX  = (1 << INT_W) - 1;
   localparam int WATCHDOG_CYC = 150000;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [CNT_W-1:0] duty_cmd = 10'd200;
   logic             ilim_in = 1'b0;
   logic             drv_a, drv_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_ramp = 0, m_phase = 0, m_duty = 0, m_integ = 0, m_hit = 0;
   int m_sync[$] = '{0, 0};

   int ha = 0, hb = 0;   // high counts accumulated by align_period

   always #10 clk = ~clk;

   pp_pwm_steer #(.CNT_W(CNT_W), .TERM_CNT(TERM), .BLANK_CYCLES(BL),
                  .INT_W(INT_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .ilim_in(ilim_in),
      .drv_a(drv_a), .drv_b(drv_b));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model advance
   always @(posedge clk) begin
      if (rst) begin
         m_ramp = 0; m_phase = 0; m_duty = 0; m_integ = 0; m_hit = 0;
         m_sync = '{0, 0};
      end else begin
         int s_out, lim, d;
         s_out = m_sync[0];
         lim   = m_hit | s_out;
         if (m_ramp == TERM) begin
            d = int'(duty_cmd) - m_integ;
            m_duty = (d < 0) ? 0 : d;
            if (lim != 0) m_integ = (m_integ < IMAX) ? m_integ + 1 : IMAX;
            else          m_integ = (m_integ > 0) ? m_integ - 1 : 0;
            m_hit   = 0;
            m_ramp  = 0;
            m_phase = 1 - m_phase;
         end else begin
            m_hit  = lim;
            m_ramp = m_ramp + 1;
         end
         void'(m_sync.pop_front());
         m_sync.push_back(int'(ilim_in));
      end
   end

   // per-cycle comparison away from the edge
   always @(negedge clk) begin
      int on, ea, eb;
      on = (!rst && m_ramp >= BL && m_ramp < m_duty && m_hit == 0) ? 1 : 0;
      ea = (on != 0 && m_phase == 0) ? 1 : 0;
      eb = (on != 0 && m_phase == 1) ? 1 : 0;
      if (!done) begin
         chk(int'(drv_a) == ea, cur_req, "drv_a vs model", int'(drv_a), ea);
         chk(int'(drv_b) == eb, cur_req, "drv_b vs model", int'(drv_b), eb);
         chk(!(drv_a && drv_b), "R3", "overlap", int'(drv_a & drv_b), 0);
      end
   end

   // advance to the next negedge where the model ramp is 0
   task automatic align_period();
      ha = 0; hb = 0;
      do begin
         @(negedge clk);
         if (m_ramp != 0) begin ha += int'(drv_a); hb += int'(drv_b); end
      end while (m_ramp != 0);
   endtask

   // measure one period starting at a ramp-0 negedge; optional action
   // kind 1: set duty_cmd to val at ramp at_r; kind 2: one-cycle ilim pulse
   task automatic run_period(output int wa, output int wb,
                             input int at_r, input int kind, input int val);
      bit clr = 0;
      wa = 0; wb = 0;
      for (int i = 0; i <= TERM; i++) begin
         if (i > 0) @(negedge clk);
         wa += int'(drv_a); wb += int'(drv_b);
         if (clr) begin #1 ilim_in = 1'b0; clr = 0; end
         if (m_ramp == at_r && kind == 1) begin #1 duty_cmd = CNT_W'(val); end
         if (m_ramp == at_r && kind == 2) begin #1 ilim_in = 1'b1; clr = 1; end
      end
      @(negedge clk);
   endtask

   task automatic set_duty_now(input int v);
      #1 duty_cmd = CNT_W'(v);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(WATCHDOG_CYC * 20);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      int wa, wb, w0, w1, w2, w3;
      // R1: reset
      repeat (5) @(negedge clk);
      chk(drv_a == 1'b0 && drv_b == 1'b0, "R1", "outputs in reset",
          int'({drv_a, drv_b}), 0);
      #1 rst = 1'b0;
      align_period();
      chk(ha == 0 && hb == 0, "R1", "first period silent", ha + hb, 0);

      // R2/R4: steady steering with duty 200
      cur_req = "R2";
      run_period(wa, wb, -1, 0, 0);
      chk(wa == 0 && wb == 196, "R2", "period 1 is B", wb, 196);
      run_period(wa, wb, -1, 0, 0);
      chk(wb == 0 && wa == 196, "R4", "period 2 is A, width", wa, 196);
      run_period(wa, wb, -1, 0, 0);
      chk(wa == 0 && wb == 196, "R2", "period 3 is B", wb, 196);

      // R5: mid-period change has no effect until next period
      cur_req = "R5";
      run_period(wa, wb, 100, 1, 50);
      chk(wa + wb == 196, "R5", "width after mid change", wa + wb, 196);
      run_period(wa, wb, -1, 0, 0);
      chk(wa + wb == 46, "R5", "width next period", wa + wb, 46);

      // R4 boundaries
      cur_req = "R4";
      set_duty_now(BL);
      run_period(wa, wb, -1, 0, 0);
      run_period(wa, wb, -1, 0, 0);
      chk(wa + wb == 0, "R4", "duty equal to blank", wa + wb, 0);
      set_duty_now(BL + 1);
      run_period(wa, wb, -1, 0, 0);
      run_period(wa, wb, -1, 0, 0);
      chk(wa + wb == 1, "R4", "duty blank+1", wa + wb, 1);
      set_duty_now(1000);
      run_period(wa, wb, -1, 0, 0);
      run_period(wa, wb, -1, 0, 0);
      chk(wa + wb == TERM + 1 - BL, "R4", "duty above terminal", wa + wb, TERM + 1 - BL);

      // R6/R8: single current-limit pulse in an A period
      cur_req = "R6";
      set_duty_now(300);
      run_period(wa, wb, -1, 0, 0);
      if (m_phase != 0) run_period(wa, wb, -1, 0, 0);
      run_period(wa, wb, 50, 2, 0);
      chk(wa == 49 && wb == 0, "R6", "cut A width", wa, 49);
      cur_req = "R8";
      run_period(wa, wb, -1, 0, 0);
      chk(wb == 296, "R8", "lag: B width uses old integrator", wb, 296);
      run_period(wa, wb, -1, 0, 0);
      chk(wa == 295, "R8", "A width reduced by integrator", wa, 295);
      run_period(wa, wb, -1, 0, 0);
      chk(wb == 296, "R7", "integrator decayed to zero", wb, 296);

      // R7: sustained overload, saturation and recovery
      cur_req = "R7";
      #1 ilim_in = 1'b1;
      w0 = 0;
      for (int p = 0; p < 20; p++) begin
         run_period(wa, wb, -1, 0, 0);
         w0 += wa + wb;
      end
      chk(w0 == 0, "R6", "sustained limit gives zero width", w0, 0);
      #1 ilim_in = 1'b0;
      run_period(wa, wb, -1, 0, 0); w0 = wa + wb;
      run_period(wa, wb, -1, 0, 0); w1 = wa + wb;
      run_period(wa, wb, -1, 0, 0); w2 = wa + wb;
      run_period(wa, wb, -1, 0, 0); w3 = wa + wb;
      chk(w0 == 0, "R7", "release period still limited", w0, 0);
      chk(w1 == 300 - IMAX - BL, "R7", "saturated integrator width", w1, 300 - IMAX - BL);
      chk(w2 == w1, "R8", "one period lag on recovery", w2, w1);
      chk(w3 == w2 + 1, "R7", "decay one per clean period", w3, w2 + 1);

      // R1: reset mid-run
      cur_req = "R1";
      repeat (37) @(negedge clk);
      #1 rst = 1'b1;
      @(negedge clk);
      chk(drv_a == 1'b0 && drv_b == 1'b0, "R1", "outputs under reset",
          int'({drv_a, drv_b}), 0);
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      align_period();
      chk(ha == 0 && hb == 0, "R1", "silent period after reset", ha + hb, 0);
      run_period(wa, wb, -1, 0, 0);
      chk(wb == 296 && wa == 0, "R2", "B after reset-silent A period", wb, 296);
      finish_run();
   end

endmodule